// File: doc/BRIEF.md
# Bidirectional GPIO Port with Direction Control

This block is a five-pin general-purpose I/O port sitting on a small register bus of a processor. Each pin has a bit in an output value register and a bit in a direction register. When a direction bit is 1, the pin is an input and its driver is off. When it is 0, the output value bit is driven onto the pin. The pad is modelled as three signals: an output enable and an output value going out, and a raw pin level coming in. The incoming level passes through a two-stage synchroniser before any logic uses it.

A read of the value register returns the synchronised pin levels, not what was written. The single-bit set and clear operations on the value register start from those pin levels. If another output pin is being held at a different level from outside, that level gets copied into the register. The highest pin can only pull low, and releases the line when its value bit is 1. Its synchronised input level is also brought out as a clock source for a timer, whether the pin is being used as an input or as an output.

Top module: `gpio_port`

## Requirements
- R1: During and after reset, every direction bit is 1 (all pins inputs, `pad_oe` all 0) and the output value register holds 0.
- R2: A direction bit of 0 on pins 0..3 drives `pad_oe` high and `pad_out` equal to that pin's value bit. A direction bit of 1 turns the driver off.
- R3: Pin 4 is open-drain. `pad_out[4]` is always 0, and `pad_oe[4]` is high only when its direction bit is 0 and its value bit is 0.
- R4: With `sel_dir`=0, `rd_data[4:0]` shows the pin levels sampled three clock edges earlier (two synchroniser stages plus the read register). With `sel_dir`=1, it shows the direction register one edge after the select is set.
- R5: `rd_data[7:5]` always reads 0. Write bits 7:5 are ignored.
- R6: `wr_en` loads `wr_data[4:0]` into the register chosen by `sel_dir` (0 = value, 1 = direction). The load takes effect at the next edge and does not look at the pins.
- R7: `bit_set` or `bit_clr` with `sel_dir`=0 stores the synchronised pin levels into the value register, with bit `bit_idx` forced to 1 or 0. A pin held low from outside therefore ends up cleared in the register.
- R8: `bit_set` or `bit_clr` with `sel_dir`=1 changes only bit `bit_idx` of the direction register, starting from its stored contents. Pin levels have no effect.
- R9: A bit operation whose `bit_idx` is 5, 6 or 7 changes no register.
- R10: `wr_en` takes precedence over a bit operation in the same cycle. When `bit_set` and `bit_clr` are both high without `wr_en`, nothing changes.
- R11: `tmr_clk` equals the pin-4 level after two synchroniser stages, in both input and output use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_dir | input | 1 | Register select: 0 value register, 1 direction register |
| wr_en | input | 1 | Full-register write strobe |
| wr_data | input | 8 | Write data |
| bit_set | input | 1 | Single-bit set strobe |
| bit_clr | input | 1 | Single-bit clear strobe |
| bit_idx | input | 3 | Bit index for set/clear |
| rd_data | output | 8 | Registered read data |
| pad_in | input | 5 | Raw pin levels from the pads |
| pad_oe | output | 5 | Pad output enables |
| pad_out | output | 5 | Pad output values |
| tmr_clk | output | 1 | Synchronised pin-4 level for a timer clock |

## Verification
The bench uses the default parameters: five pins, an 8-bit bus, a 3-bit index, and the open-drain pin at the top position. The 3-bit index can name positions 5 to 7, which no pin has, so the bench can drive the ignored-index cases on purpose. The bench models each pin as pulled high unless the block or an external force drives it. This lets it hold an output pin low against the block and show that the low level leaks into the register on a bit operation. Because the synchroniser depth is fixed at two, the bench can sample the read and timer-clock outputs on the exact edge where a pin change first appears.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Register operation selected for the current cycle
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LOAD = 2'd1,
    OP_SET  = 2'd2,
    OP_CLR  = 2'd3
  } gpio_op_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_decode.sv
module gpio_decode
  import gpio_pkg::*;
#(
  parameter int WIDTH = 5,
  parameter int IDX_W = 3
) (
  input  logic             sel_dir,
  input  logic             wr_en,
  input  logic             bit_set,
  input  logic             bit_clr,
  input  logic [IDX_W-1:0] bit_idx,
  output gpio_op_e         op,
  output logic             hit_val,
  output logic             hit_dir
);

  logic idx_ok;

  assign idx_ok = (int'(bit_idx) < WIDTH);

  always_comb begin
    op = OP_NONE;
    if (wr_en)                             op = OP_LOAD;
    else if (bit_set && !bit_clr && idx_ok) op = OP_SET;
    else if (bit_clr && !bit_set && idx_ok) op = OP_CLR;
  end

  assign hit_val = !sel_dir;
  assign hit_dir = sel_dir;

endmodule

// File: rtl/gpio_latch.sv
module gpio_latch
  import gpio_pkg::*;
#(
  parameter int             W       = 5,
  parameter int             IDX_W   = 3,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  gpio_op_e         op,
  input  logic             hit,
  input  logic [W-1:0]     load_val,
  input  logic [W-1:0]     base_val,
  input  logic [IDX_W-1:0] idx,
  output logic [W-1:0]     q
);

  logic [W-1:0] mask;
  logic [W-1:0] nxt;

  assign mask = {{(W-1){1'b0}}, 1'b1} << idx;

  always_comb begin
    nxt = q;
    if (hit) begin
      unique case (op)
        OP_LOAD: nxt = load_val;
        OP_SET:  nxt = base_val | mask;
        OP_CLR:  nxt = base_val & ~mask;
        default: nxt = q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= nxt;
  end

endmodule

// File: rtl/gpio_pad_drv.sv
module gpio_pad_drv #(
  parameter int WIDTH  = 5,
  parameter int OD_BIT = 4
) (
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] val_q,
  output logic [WIDTH-1:0] oe,
  output logic [WIDTH-1:0] out
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (i == OD_BIT) begin : g_od
      // pull-low only: enable when value is 0, release otherwise
      assign oe[i]  = ~dir_q[i] & ~val_q[i];
      assign out[i] = 1'b0;
    end else begin : g_pp
      assign oe[i]  = ~dir_q[i];
      assign out[i] = val_q[i];
    end
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int WIDTH  = 5,
  parameter int BUS_W  = 8,
  parameter int IDX_W  = 3,
  parameter int OD_BIT = 4,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_dir,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             bit_set,
  input  logic             bit_clr,
  input  logic [IDX_W-1:0] bit_idx,
  output logic [BUS_W-1:0] rd_data,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic             tmr_clk
);

  localparam int PAD_HI = BUS_W - WIDTH;

  gpio_op_e         op;
  logic             hit_val;
  logic             hit_dir;
  logic [WIDTH-1:0] pin_s;
  logic [WIDTH-1:0] val_q;
  logic [WIDTH-1:0] dir_q;
  logic [BUS_W-1:0] rd_q;
  logic             wr_unused_hi;

  assign wr_unused_hi = ^wr_data[BUS_W-1:WIDTH];

  gpio_sync #(.W(WIDTH), .STAGES(SYNC_N)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pin_s)
  );

  gpio_decode #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_dec (
    .sel_dir (sel_dir),
    .wr_en   (wr_en),
    .bit_set (bit_set),
    .bit_clr (bit_clr),
    .bit_idx (bit_idx),
    .op      (op),
    .hit_val (hit_val),
    .hit_dir (hit_dir)
  );

  // value register: bit operations start from the pin levels
  gpio_latch #(.W(WIDTH), .IDX_W(IDX_W), .RST_VAL('0)) u_val (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .hit      (hit_val),
    .load_val (wr_data[WIDTH-1:0]),
    .base_val (pin_s),
    .idx      (bit_idx),
    .q        (val_q)
  );

  // direction register: bit operations start from its own contents
  gpio_latch #(.W(WIDTH), .IDX_W(IDX_W), .RST_VAL('1)) u_dir (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .hit      (hit_dir),
    .load_val (wr_data[WIDTH-1:0]),
    .base_val (dir_q),
    .idx      (bit_idx),
    .q        (dir_q)
  );

  gpio_pad_drv #(.WIDTH(WIDTH), .OD_BIT(OD_BIT)) u_pad (
    .dir_q (dir_q),
    .val_q (val_q),
    .oe    (pad_oe),
    .out   (pad_out)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= {{PAD_HI{1'b0}}, (sel_dir ? dir_q : pin_s)};
  end

  assign rd_data = rd_q;
  assign tmr_clk = pin_s[OD_BIT];

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH  = 5,
  parameter int BUS_W  = 8,
  parameter int IDX_W  = 3,
  parameter int OD_BIT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             sel_dir,
  input logic             wr_en,
  input logic [BUS_W-1:0] wr_data,
  input logic             bit_set,
  input logic             bit_clr,
  input logic [IDX_W-1:0] bit_idx,
  input logic [BUS_W-1:0] rd_data,
  input logic [WIDTH-1:0] pad_in,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_out,
  input logic             tmr_clk
);

  localparam logic [WIDTH-1:0] PP_MASK = ~(WIDTH'(1) << OD_BIT);

  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                   since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_reset_inputs_R1: assert property (@(posedge clk)
    $past(rst) |-> (pad_oe == '0));

  assert_dir_load_R2: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && sel_dir) |->
      ((pad_oe & PP_MASK) == (~$past(wr_data[WIDTH-1:0]) & PP_MASK)));

  assert_od_release_R3: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && !sel_dir && wr_data[OD_BIT]) |-> !pad_oe[OD_BIT]);

  assert_pin_read_R4: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && !$past(sel_dir)) |->
      (rd_data[WIDTH-1:0] == $past(pad_in, 3)));

  assert_set_R7: assert property (@(posedge clk) disable iff (rst)
    $past(bit_set && !bit_clr && !wr_en && !sel_dir &&
          int'(bit_idx) < WIDTH && int'(bit_idx) != OD_BIT)
      |-> pad_out[$past(bit_idx)]);

  assert_clr_R7: assert property (@(posedge clk) disable iff (rst)
    $past(bit_clr && !bit_set && !wr_en && !sel_dir &&
          int'(bit_idx) < WIDTH && int'(bit_idx) != OD_BIT)
      |-> !pad_out[$past(bit_idx)]);

  assert_bad_idx_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!wr_en && (bit_set ^ bit_clr) && int'(bit_idx) >= WIDTH)
      |-> ($stable(pad_oe) && $stable(pad_out)));

  assert_tmr_R11: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2) |-> (tmr_clk == $past(pad_in[OD_BIT], 2)));

endmodule

bind gpio_port gpio_port_chk #(
  .WIDTH(WIDTH), .BUS_W(BUS_W), .IDX_W(IDX_W), .OD_BIT(OD_BIT)
) u_chk (.*);

// File: tb/test_gpio_port.sv
module test_gpio_port;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_dir = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       bit_set = 1'b0;
  logic       bit_clr = 1'b0;
  logic [2:0] bit_idx = '0;
  logic [7:0] rd_data;
  logic [4:0] pad_in;
  logic [4:0] pad_oe;
  logic [4:0] pad_out;
  logic       tmr_clk;

  logic [4:0] frc_en  = '0;
  logic [4:0] frc_val = '0;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  // pin model: external force wins, else block driver, else pull-up
  assign pad_in = (frc_en & frc_val) | (~frc_en & ((pad_oe & pad_out) | ~pad_oe));

  gpio_port i_gpio_port (
    .clk(clk), .rst(rst), .sel_dir(sel_dir), .wr_en(wr_en), .wr_data(wr_data),
    .bit_set(bit_set), .bit_clr(bit_clr), .bit_idx(bit_idx), .rd_data(rd_data),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .tmr_clk(tmr_clk)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic dsel, input logic [7:0] v);
    sel_dir = dsel; wr_en = 1'b1; wr_data = v;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic bit_op(input logic dsel, input logic s, input logic c, input logic [2:0] i);
    sel_dir = dsel; bit_set = s; bit_clr = c; bit_idx = i;
    cyc(1);
    bit_set = 1'b0; bit_clr = 1'b0;
  endtask

  task automatic rd_reg(input logic dsel, output logic [7:0] v);
    sel_dir = dsel;
    cyc(4);
    v = rd_data;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    cyc(4); rst = 1'b0;
    check("R1 pad_oe after reset", {3'b0, pad_oe}, 8'h00);
    rd_reg(1'b1, v); check("R1 direction reset", v, 8'h1F);
    rd_reg(1'b0, v); check("R1 inputs pulled", v, 8'h1F);
    wr_reg(1'b1, 8'h00);
    rd_reg(1'b0, v); check("R1 value reg zero", v, 8'h00);
    check("R2 all drivers on", {3'b0, pad_oe}, 8'h1F);
  endtask

  task automatic t_full_write;
    logic [7:0] v;
    wr_reg(1'b0, 8'hF5);
    rd_reg(1'b0, v); check("R6 R5 value load", v, 8'h15);
    check("R3 od released", {3'b0, pad_oe}, 8'h0F);
    check("R3 od out low", {7'b0, pad_out[4]}, 8'h00);
    wr_reg(1'b1, 8'hE0);
    rd_reg(1'b1, v); check("R5 upper ignored", v, 8'h00);
    wr_reg(1'b0, 8'h05);
    rd_reg(1'b0, v); check("R3 od pulls low", v, 8'h05);
    check("R3 od enable", {7'b0, pad_oe[4]}, 8'h01);
  endtask

  task automatic t_rmw;
    logic [7:0] v;
    wr_reg(1'b0, 8'h03);
    frc_en = 5'h02; frc_val = 5'h00;
    cyc(4);
    bit_op(1'b0, 1'b1, 1'b0, 3'd2);
    check("R7 hazard latch", {4'b0, pad_out[3:0]}, 8'h05);
    frc_en = '0;
    rd_reg(1'b0, v); check("R7 hazard pins", v, 8'h05);
    bit_op(1'b0, 1'b0, 1'b1, 3'd0);
    check("R7 clear", {4'b0, pad_out[3:0]}, 8'h04);
    cyc(3);
    bit_op(1'b0, 1'b1, 1'b0, 3'd4);
    rd_reg(1'b0, v); check("R7 R3 set od bit", v, 8'h14);
    check("R3 od off after set", {7'b0, pad_oe[4]}, 8'h00);
  endtask

  task automatic t_ignored;
    logic [7:0] v;
    bit_op(1'b0, 1'b1, 1'b0, 3'd6);
    bit_op(1'b0, 1'b0, 1'b1, 3'd5);
    bit_op(1'b1, 1'b1, 1'b0, 3'd7);
    check("R9 value unchanged", {4'b0, pad_out[3:0]}, 8'h04);
    check("R9 dir unchanged", {3'b0, pad_oe}, 8'h0F);
    rd_reg(1'b0, v); check("R9 pins unchanged", v, 8'h14);
    bit_op(1'b0, 1'b1, 1'b1, 3'd0);
    check("R10 both strobes", {4'b0, pad_out[3:0]}, 8'h04);
    sel_dir = 1'b0; wr_en = 1'b1; wr_data = 8'h0C; bit_clr = 1'b1; bit_idx = 3'd2;
    cyc(1);
    wr_en = 1'b0; bit_clr = 1'b0;
    check("R10 write wins", {4'b0, pad_out[3:0]}, 8'h0C);
  endtask

  task automatic t_dir_bits;
    logic [7:0] v;
    wr_reg(1'b1, 8'h00);
    bit_op(1'b1, 1'b1, 1'b0, 3'd0);
    check("R8 dir set", {7'b0, pad_oe[0]}, 8'h00);
    frc_en = 5'h08; frc_val = 5'h00;
    cyc(4);
    bit_op(1'b1, 1'b1, 1'b0, 3'd1);
    rd_reg(1'b1, v); check("R8 dir ignores pins", v, 8'h03);
    frc_en = '0;
  endtask

  task automatic t_sync;
    wr_reg(1'b1, 8'h1F);
    sel_dir = 1'b0;
    cyc(5);
    frc_en = 5'h1F; frc_val = 5'h0A;
    cyc(1);
    check("R11 tmr one edge", {7'b0, tmr_clk}, 8'h01);
    cyc(1);
    check("R11 tmr two edges", {7'b0, tmr_clk}, 8'h00);
    check("R4 read two edges", rd_data, 8'h1F);
    cyc(1);
    check("R4 read three edges", rd_data, 8'h0A);
    frc_en = '0;
  endtask

  task automatic t_tmr_out;
    wr_reg(1'b1, 8'h00);
    wr_reg(1'b0, 8'h00);
    cyc(4);
    check("R11 tmr out low", {7'b0, tmr_clk}, 8'h00);
    wr_reg(1'b0, 8'h10);
    cyc(4);
    check("R11 tmr out high", {7'b0, tmr_clk}, 8'h01);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_full_write();
        t_rmw();
        t_ignored();
        t_dir_bits();
        t_sync();
        t_tmr_out();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule